// File: doc/BRIEF.md
# Programmable Interval Timer Channel

This block is one 16-bit down-counting timer channel of an interval timer. Software reaches it through a byte-wide bus with two locations: a control location and a count data location. A control byte either configures the channel (operating mode and byte access order) or freezes a snapshot of the running count. The count itself is loaded and read one byte at a time. One internal byte pointer serves both loading and reading.

The counter moves only on clock cycles where the count-enable input `cnt_tick` is high. Three operating modes are provided. Mode 0 raises the output once at terminal count. Mode 2 is a rate generator that reloads itself and produces one event per period. Mode 4 is a software-triggered strobe for one-shot use. Each terminal-count event also produces a one-cycle interrupt pulse.

Top module: `pit_channel`

## Requirements
- R1: Control byte decode.
  - Bits [7:6] must be 00, meaning this channel. Bit 0 must be 0, meaning binary counting.
  - Bits [5:4] select access: 01 is low byte only, 10 is high byte only (low byte taken as zero), 11 is low byte then high byte, and 00 is the latch command.
  - Bits [3:1] select the mode: 000 is mode 0, x10 is mode 2, and 100 is mode 4.
  - A control byte with any other channel, any other mode code, or bit 0 set changes nothing.
- R2: Reset state, and the state after every accepted mode byte:
  - counting is stopped;
  - the byte pointer expects the low byte;
  - any pending snapshot is discarded;
  - `tmr_out` is low in mode 0 and high in modes 2 and 4.
  - After reset the mode is 0 with low-then-high access, the count is 0, `tmr_out` is 0 and `bus_rdata` is 0.
- R3: Loading in low-then-high access:
  - The first data write carries bits [7:0] of the count and the second carries bits [15:8].
  - Counting starts from the clock edge that takes the completing byte.
  - In modes 0 and 4, the first byte stops a count that is in progress.
- R4: In modes 0 and 4, `irq_pulse` is high for exactly one clock, in the cycle after the N-th tick that follows loading count N.
  - After that event the count stays at 0 with no reload and no further pulse.
  - `irq_pulse` is only ever high in the cycle after a tick.
- R5: In mode 2 the count reloads from the loaded value when it would reach zero, giving one `irq_pulse` every N ticks.
- R6: A loaded count of 0 behaves as 65536 ticks.
- R7: Latch command and readback:
  - The latch command captures the live count while counting carries on.
  - The next data read returns bits [7:0] of the snapshot and the one after returns bits [15:8]; the snapshot is then released.
  - With no snapshot held, reads return the live count.
- R8: A latch command issued while a snapshot is still held is ignored, so the first snapshot is the one read back.
- R9: One-shot counts from 0x000F to 0x7FFF time out after exactly that many ticks.
- R10: Output level:
  - In mode 0, `tmr_out` is low while counting and high from terminal count on.
  - In mode 2, it is low only while the count equals 1.
  - In mode 4, it is low from terminal count until the next tick.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| bus_wr | input | 1 | Byte write strobe |
| bus_rd | input | 1 | Byte read strobe; advances the read side effects |
| bus_sel | input | 1 | 1 selects the control location, 0 the count data location |
| bus_wdata | input | 8 | Write byte |
| bus_rdata | output | 8 | Read byte, valid combinationally for the data location |
| cnt_tick | input | 1 | Count-enable tick, one count per high cycle |
| tmr_out | output | 1 | Timer output level |
| irq_pulse | output | 1 | One-cycle terminal-count event |

## Verification
The properties assume that the bus never issues a read and a write in the same cycle. They also assume that reads are issued only when the pointer state is meaningful, that is, after a complete load or a latch. The bench drives one bus operation per clock with `cnt_tick` held low during it. It steps ticks one cycle at a time, with random idle gaps that change the cycle count but never the tick count. Mode-2 reload values stay at 15 or more, so the periodic properties never meet a period of one tick.

// File: rtl/pit_pkg.sv
package pit_pkg;

    typedef enum logic [1:0] {
        MD_TC     = 2'd0,
        MD_RATE   = 2'd1,
        MD_STROBE = 2'd2
    } pit_mode_e;

    typedef enum logic [1:0] {
        AC_LATCH = 2'd0,
        AC_LO    = 2'd1,
        AC_HI    = 2'd2,
        AC_LOHI  = 2'd3
    } pit_acc_e;

    function automatic logic mode_code_ok(input logic [2:0] f);
        return (f == 3'b000) || (f[1:0] == 2'b10) || (f == 3'b100);
    endfunction

    function automatic pit_mode_e mode_code_map(input logic [2:0] f);
        if (f[1:0] == 2'b10)  return MD_RATE;
        else if (f == 3'b100) return MD_STROBE;
        else                  return MD_TC;
    endfunction

endpackage

// File: rtl/pit_regif.sv
module pit_regif
    import pit_pkg::*;
#(
    parameter int BYTE_W = 8
) (
    input  logic                  clk,
    input  logic                  rst_n,
    input  logic                  bus_wr,
    input  logic                  bus_rd,
    input  logic                  bus_sel,
    input  logic [BYTE_W-1:0]     bus_wdata,
    output logic [BYTE_W-1:0]     bus_rdata,
    input  logic [2*BYTE_W-1:0]   cur_count,
    output pit_mode_e             mode,
    output pit_mode_e             cfg_mode,
    output logic                  cfg_wr,
    output logic                  load,
    output logic [2*BYTE_W-1:0]   load_val,
    output logic                  halt
);
    localparam int CNT_W = 2 * BYTE_W;

    typedef struct packed {
        pit_mode_e           mode;
        pit_acc_e            acc;
        logic                ptr_hi;
        logic [BYTE_W-1:0]   lsb_hold;
        logic                latched;
        logic [CNT_W-1:0]    snap;
    } rif_t;

    rif_t s_d, s_q;

    logic             ctrl_w, data_w, data_r, chan_ok;
    logic [CNT_W-1:0] word_sel;
    logic             hi_sel;

    always_comb begin
        s_d      = s_q;
        cfg_wr   = 1'b0;
        load     = 1'b0;
        halt     = 1'b0;
        load_val = '0;
        cfg_mode = mode_code_map(bus_wdata[3:1]);
        ctrl_w   = bus_wr && bus_sel;
        data_w   = bus_wr && !bus_sel;
        data_r   = bus_rd && !bus_sel && !bus_wr;
        chan_ok  = (bus_wdata[7:6] == 2'b00);

        if (ctrl_w) begin
            if (chan_ok && bus_wdata[5:4] == 2'b00) begin
                if (!s_q.latched) begin
                    s_d.latched = 1'b1;
                    s_d.snap    = cur_count;
                end
            end else if (chan_ok && mode_code_ok(bus_wdata[3:1]) && !bus_wdata[0]) begin
                s_d.mode    = cfg_mode;
                s_d.acc     = pit_acc_e'(bus_wdata[5:4]);
                s_d.ptr_hi  = 1'b0;
                s_d.latched = 1'b0;
                cfg_wr      = 1'b1;
            end
        end else if (data_w) begin
            unique case (s_q.acc)
                AC_LO: begin
                    load     = 1'b1;
                    load_val = {{BYTE_W{1'b0}}, bus_wdata};
                end
                AC_HI: begin
                    load     = 1'b1;
                    load_val = {bus_wdata, {BYTE_W{1'b0}}};
                end
                AC_LOHI: begin
                    if (!s_q.ptr_hi) begin
                        s_d.lsb_hold = bus_wdata;
                        s_d.ptr_hi   = 1'b1;
                        halt         = (s_q.mode != MD_RATE);
                    end else begin
                        s_d.ptr_hi = 1'b0;
                        load       = 1'b1;
                        load_val   = {bus_wdata, s_q.lsb_hold};
                    end
                end
                default: ;
            endcase
        end else if (data_r) begin
            if (s_q.acc == AC_LOHI) begin
                s_d.ptr_hi = !s_q.ptr_hi;
                if (s_q.ptr_hi) s_d.latched = 1'b0;
            end else begin
                s_d.latched = 1'b0;
            end
        end

        word_sel  = s_q.latched ? s_q.snap : cur_count;
        hi_sel    = (s_q.acc == AC_HI) || (s_q.acc == AC_LOHI && s_q.ptr_hi);
        bus_rdata = hi_sel ? word_sel[CNT_W-1:BYTE_W] : word_sel[BYTE_W-1:0];
        mode      = s_q.mode;
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            s_q.mode     <= MD_TC;
            s_q.acc      <= AC_LOHI;
            s_q.ptr_hi   <= 1'b0;
            s_q.lsb_hold <= '0;
            s_q.latched  <= 1'b0;
            s_q.snap     <= '0;
        end else begin
            s_q <= s_d;
        end
    end

    AST_SNAP_FROZEN: assert property (@(posedge clk) disable iff (!rst_n)
        (s_q.latched && !cfg_wr) |=> (s_q.snap == $past(s_q.snap))); // R8

    AST_CFG_CLEARS_PTR: assert property (@(posedge clk) disable iff (!rst_n)
        cfg_wr |=> (!s_q.latched && !s_q.ptr_hi)); // R2

    AST_SINGLE_ACTION: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0({cfg_wr, load, halt})); // R3

endmodule

// File: rtl/pit_engine.sv
module pit_engine
    import pit_pkg::*;
#(
    parameter int CNT_W = 16
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              tick,
    input  pit_mode_e         mode,
    input  pit_mode_e         cfg_mode,
    input  logic              cfg_wr,
    input  logic              load,
    input  logic [CNT_W-1:0]  load_val,
    input  logic              halt,
    output logic [CNT_W-1:0]  count,
    output logic              tmr_out,
    output logic              irq_pulse
);
    localparam logic [CNT_W-1:0] ONE = CNT_W'(1);

    typedef struct packed {
        logic [CNT_W-1:0] count;
        logic [CNT_W-1:0] reload;
        logic             running;
        logic             done;
        logic             out;
        logic             irq;
    } eng_t;

    eng_t e_d, e_q;
    logic [CNT_W-1:0] dec;

    always_comb begin
        e_d     = e_q;
        e_d.irq = 1'b0;
        dec     = e_q.count - ONE;

        if (cfg_wr) begin
            e_d.running = 1'b0;
            e_d.done    = 1'b0;
            e_d.out     = (cfg_mode != MD_TC);
        end else if (load) begin
            e_d.count   = load_val;
            e_d.reload  = load_val;
            e_d.running = 1'b1;
            e_d.done    = 1'b0;
            e_d.out     = (mode != MD_TC) && !(mode == MD_RATE && load_val == ONE);
        end else if (halt) begin
            e_d.running = 1'b0;
        end else if (e_q.running && tick) begin
            if (e_q.count == ONE) begin
                e_d.irq = 1'b1;
                unique case (mode)
                    MD_RATE: begin
                        e_d.count = e_q.reload;
                        e_d.out   = (e_q.reload != ONE);
                    end
                    MD_STROBE: begin
                        e_d.count   = '0;
                        e_d.running = 1'b0;
                        e_d.done    = 1'b1;
                        e_d.out     = 1'b0;
                    end
                    default: begin
                        e_d.count   = '0;
                        e_d.running = 1'b0;
                        e_d.done    = 1'b1;
                        e_d.out     = 1'b1;
                    end
                endcase
            end else begin
                e_d.count = dec;
                if (mode == MD_RATE) e_d.out = (dec != ONE);
            end
        end else if (tick && e_q.done && mode == MD_STROBE) begin
            e_d.out = 1'b1;
        end

        count     = e_q.count;
        tmr_out   = e_q.out;
        irq_pulse = e_q.irq;
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            e_q <= '0;
        end else begin
            e_q <= e_d;
        end
    end

    AST_STEP_DOWN: assert property (@(posedge clk) disable iff (!rst_n)
        (e_q.running && tick && e_q.count != ONE && !cfg_wr && !load && !halt)
        |=> (e_q.count == $past(e_q.count) - ONE)); // R4

    AST_RATE_RELOAD: assert property (@(posedge clk) disable iff (!rst_n)
        (e_q.running && tick && e_q.count == ONE && mode == MD_RATE && !cfg_wr && !load && !halt)
        |=> (e_q.count == $past(e_q.reload) && irq_pulse)); // R5

    AST_ONESHOT_PARKED: assert property (@(posedge clk) disable iff (!rst_n)
        (e_q.done && !cfg_wr && !load) |=> (e_q.count == '0 && !e_q.running && !irq_pulse)); // R4

    AST_IRQ_AFTER_TICK: assert property (@(posedge clk) disable iff (!rst_n)
        irq_pulse |-> $past(tick)); // R4

    AST_TC_OUT_LOW: assert property (@(posedge clk) disable iff (!rst_n)
        (mode == MD_TC && e_q.running) |-> !tmr_out); // R10

endmodule

// File: rtl/pit_channel.sv
module pit_channel
    import pit_pkg::*;
#(
    parameter int BYTE_W = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              bus_wr,
    input  logic              bus_rd,
    input  logic              bus_sel,
    input  logic [BYTE_W-1:0] bus_wdata,
    output logic [BYTE_W-1:0] bus_rdata,
    input  logic              cnt_tick,
    output logic              tmr_out,
    output logic              irq_pulse
);
    localparam int CNT_W = 2 * BYTE_W;

    pit_mode_e        mode, cfg_mode;
    logic             cfg_wr, load, halt;
    logic [CNT_W-1:0] load_val, count;

    pit_regif #(.BYTE_W(BYTE_W)) u_regif (
        .clk       (clk),
        .rst_n     (rst_n),
        .bus_wr    (bus_wr),
        .bus_rd    (bus_rd),
        .bus_sel   (bus_sel),
        .bus_wdata (bus_wdata),
        .bus_rdata (bus_rdata),
        .cur_count (count),
        .mode      (mode),
        .cfg_mode  (cfg_mode),
        .cfg_wr    (cfg_wr),
        .load      (load),
        .load_val  (load_val),
        .halt      (halt)
    );

    pit_engine #(.CNT_W(CNT_W)) u_engine (
        .clk       (clk),
        .rst_n     (rst_n),
        .tick      (cnt_tick),
        .mode      (mode),
        .cfg_mode  (cfg_mode),
        .cfg_wr    (cfg_wr),
        .load      (load),
        .load_val  (load_val),
        .halt      (halt),
        .count     (count),
        .tmr_out   (tmr_out),
        .irq_pulse (irq_pulse)
    );

endmodule

// File: tb/pit_channel_test.sv
module pit_channel_test;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       bus_wr = 1'b0, bus_rd = 1'b0, bus_sel = 1'b0, cnt_tick = 1'b0;
    logic [7:0] bus_wdata = 8'h00;
    logic [7:0] bus_rdata;
    logic       tmr_out, irq_pulse;

    int total = 0;
    int fails = 0;
    bit done_flag = 1'b0;

    always #4 clk = ~clk;

    pit_channel uut (
        .clk(clk), .rst_n(rst_n), .bus_wr(bus_wr), .bus_rd(bus_rd),
        .bus_sel(bus_sel), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
        .cnt_tick(cnt_tick), .tmr_out(tmr_out), .irq_pulse(irq_pulse)
    );

    function automatic int ctrl_byte(input int md);
        return (md == 0) ? 'h30 : (md == 2) ? 'h34 : 'h38;
    endfunction

    function automatic int ticks_for(input int n);
        return (n == 0) ? 65536 : n;
    endfunction

    task automatic chk(input string req, input int act, input int exp);
        total++;
        if (act != exp) begin
            fails++;
            $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    task automatic wr(input bit sel, input int b);
        bus_wr = 1'b1; bus_sel = sel; bus_wdata = 8'(b);
        @(negedge clk);
        bus_wr = 1'b0; bus_sel = 1'b0;
    endtask

    task automatic rd_byte(output int v);
        v = int'(bus_rdata);
        bus_rd = 1'b1;
        @(negedge clk);
        bus_rd = 1'b0;
    endtask

    task automatic rd_word(output int v);
        int lo, hi;
        rd_byte(lo);
        rd_byte(hi);
        v = lo | (hi << 8);
    endtask

    task automatic load16(input int md, input int n);
        wr(1'b1, ctrl_byte(md));
        wr(1'b0, n & 'hFF);
        wr(1'b0, (n >> 8) & 'hFF);
    endtask

    task automatic tick_one(input int gap);
        repeat (gap) @(negedge clk);
        cnt_tick = 1'b1;
        @(negedge clk);
        cnt_tick = 1'b0;
    endtask

    task automatic count_to_irq(input int limit, input int gmax, output int n);
        n = 0;
        for (int i = 0; i < limit; i++) begin
            tick_one(gmax > 0 ? int'($urandom_range(gmax, 0)) : 0);
            n++;
            if (irq_pulse) break;
        end
    endtask

    initial begin
        repeat (190000) @(posedge clk);
        if (!done_flag) begin
            total++; fails++;
            $display("FAIL watchdog actual=timeout expected=finish");
            $display("*** SUMMARY: %0d compared / %0d mismatched ***", total, fails);
            $finish;
        end
    end

    initial begin
        int n, v, irqs;
        void'($urandom(32'd4711));
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);

        chk("R2 reset tmr_out", int'(tmr_out), 0);
        chk("R2 reset irq", int'(irq_pulse), 0);
        chk("R2 reset rdata", int'(bus_rdata), 0);

        // R9 / R4 minimum one-shot
        load16(4, 'h000F);
        count_to_irq(100, 0, n);
        chk("R9 min one-shot", n, 15);
        irqs = 0;
        for (int i = 0; i < 20; i++) begin tick_one(0); irqs += int'(irq_pulse); end
        chk("R4 no second pulse", irqs, 0);
        wr(1'b1, 'h00); rd_word(v);
        chk("R4 count parked at zero", v, 0);

        // R9 maximum one-shot
        load16(4, 'h7FFF);
        count_to_irq(40000, 0, n);
        chk("R9 max one-shot", n, 'h7FFF);

        // R10 / R2 mode 0 output
        wr(1'b1, 'h30);
        chk("R2 mode0 out low", int'(tmr_out), 0);
        wr(1'b0, 25); wr(1'b0, 0);
        for (int i = 1; i <= 25; i++) begin
            tick_one(0);
            if (i == 24) chk("R10 mode0 out before tc", int'(tmr_out), 0);
            if (i == 25) begin
                chk("R4 mode0 irq at tc", int'(irq_pulse), 1);
                chk("R10 mode0 out after tc", int'(tmr_out), 1);
            end
        end

        // R10 mode 4 strobe
        load16(4, 30);
        chk("R2 mode4 out high", int'(tmr_out), 1);
        count_to_irq(100, 0, n);
        chk("R4 mode4 period", n, 30);
        chk("R10 mode4 strobe low", int'(tmr_out), 0);
        tick_one(0);
        chk("R10 mode4 strobe ends", int'(tmr_out), 1);

        // R5 / R10 mode 2 rate
        load16(2, 40);
        count_to_irq(100, 0, n);
        chk("R5 first period", n, 40);
        for (int i = 1; i <= 40; i++) begin
            tick_one(0);
            if (i == 38) chk("R10 rate out high", int'(tmr_out), 1);
            if (i == 39) chk("R10 rate out low at one", int'(tmr_out), 0);
            if (i < 40 && irq_pulse) chk("R5 early pulse", 1, 0);
            if (i == 40) chk("R5 second period", int'(irq_pulse), 1);
        end

        // R7 latch
        load16(2, 1000);
        repeat (100) tick_one(0);
        wr(1'b1, 'h00);
        repeat (50) tick_one(0);
        rd_word(v);
        chk("R7 snapshot", v, 900);
        wr(1'b1, 'h00); rd_word(v);
        chk("R7 released then live", v, 850);

        // R8 second latch ignored
        wr(1'b1, 'h00);
        repeat (10) tick_one(0);
        wr(1'b1, 'h00);
        repeat (10) tick_one(0);
        rd_word(v);
        chk("R8 first snapshot kept", v, 850);
        wr(1'b1, 'h00); rd_word(v);
        chk("R8 later latch", v, 830);

        // R2 mode byte cancels latch and resets pointer
        wr(1'b1, 'h00);
        repeat (5) tick_one(0);
        wr(1'b1, 'h38);
        rd_word(v);
        chk("R2 latch cancelled", v, 825);
        wr(1'b0, 'h55);
        wr(1'b1, 'h38);
        wr(1'b0, 'h20); wr(1'b0, 'h00);
        count_to_irq(100, 0, n);
        chk("R2 pointer reset", n, 32);

        // R1 ignored control bytes
        load16(2, 50);
        repeat (10) tick_one(0);
        wr(1'b1, 'h74); wr(1'b1, 'h32); wr(1'b1, 'h35);
        wr(1'b1, 'h00); rd_word(v);
        chk("R1 ignored bytes keep count", v, 40);
        count_to_irq(100, 0, n);
        chk("R1 ignored bytes keep mode", n, 40);

        // R1 single-byte access orders
        wr(1'b1, 'h18); wr(1'b0, 40);
        count_to_irq(100, 0, n);
        chk("R1 low-only access", n, 40);
        wr(1'b1, 'h28); wr(1'b0, 1);
        count_to_irq(400, 0, n);
        chk("R1 high-only access", n, 256);

        // R3 first byte halts a one-shot
        load16(4, 20);
        repeat (19) tick_one(0);
        wr(1'b0, 'h0A);
        irqs = 0;
        for (int i = 0; i < 5; i++) begin tick_one(0); irqs += int'(irq_pulse); end
        chk("R3 first byte halts", irqs, 0);
        wr(1'b0, 'h00);
        count_to_irq(100, 0, n);
        chk("R3 new count after high byte", n, 10);

        // R6 zero means 65536
        load16(4, 0);
        count_to_irq(70000, 0, n);
        chk("R6 zero count", n, ticks_for(0));

        // Random mix of modes, counts and tick gaps
        for (int it = 0; it < 8; it++) begin
            int md, cnt;
            md  = 2 * int'($urandom_range(2, 0));
            cnt = int'($urandom_range(300, 15));
            load16(md, cnt);
            count_to_irq(cnt + 5, 2, n);
            chk(md == 2 ? "R5 random period" : "R4 random one-shot", n, ticks_for(cnt));
            if (md == 2) begin
                count_to_irq(cnt + 5, 2, n);
                chk("R5 random reload", n, ticks_for(cnt));
            end
        end

        done_flag = 1'b1;
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", total, fails);
        $finish;
    end

endmodule